// File: doc/BRIEF.md
# Dual-Channel Enable, Soft-Start and Power-Good Sequencer

This block sequences two switching supply channels from their enable levels and an input-supply power-on-reset flag. For each channel it produces a run flag and a digital reference code that ramps from zero to full scale after the channel is enabled, so the regulation loop tracks the ramp instead of its final target. It also drives the enable of the 5 V auxiliary regulator (on when either channel is enabled), the enable of the 3.3 V regulator (on whenever input power is good), and one shared open-drain power-good pin.

Power-good is a logical AND over both channels. It is released only when both channels are enabled, both ramps have reached full scale, both feedback levels are inside their windows, and the external protection block reports no fault. Each channel's window flag sets when its feedback crosses the rising release comparator and clears when the feedback falls below the lower comparator or rises above the overvoltage comparator, which gives the detection its hysteresis. The open-drain pin is modelled as an active-low pull-down enable: a low output pulls the pin low, a high output leaves it released.

All inputs are level signals sampled on the clock; the block has no data stream and so no handshake.

Top module: `dual_rail_seq`

## Requirements
- R1: While a channel is active (power-on-reset satisfied and its enable high), its reference code starts at 0 and rises by exactly one code after every STEP_CLKS active clocks, reaching the all-ones full-scale code and holding there.
- R2: One clock after a channel becomes inactive its reference code is 0 and its run flag is low; a later enable restarts the ramp from code 0.
- R3: Each run flag equals, one clock later, power-on-reset AND that channel's enable.
- R4: The 5 V regulator enable equals, one clock later, power-on-reset AND (either enable); with both enables low it is low (standby).
- R5: The 3.3 V regulator enable equals, one clock later, the power-on-reset flag, regardless of the enables.
- R6: The power-good drive output is 0 (pin pulled low) during reset, in standby, and while either channel's reference code is below full scale.
- R7: With only one channel enabled, the power-good drive output stays 0 even after that channel's ramp completes.
- R8: A channel's window flag sets when its rising comparator is high (and no overvoltage), and stays set while the lower comparator stays high even if the rising comparator drops; once cleared it sets again only via the rising comparator.
- R9: The lower comparator going low or the overvoltage comparator going high on either channel makes the drive output 0 at the next clock edge; overvoltage wins over the rising comparator.
- R10: The fault input high makes the drive output 0 at the next clock edge.
- R11: The drive output goes to 1 at the first clock edge at which both channels are active, both codes already sit at full scale, both window flags are set (including updates at that edge) and no fault is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Input supply above its power-on-reset level |
| en | input | NCH | Per-channel enable level |
| fb_rise | input | NCH | Feedback above the rising release threshold (about 88 %) |
| fb_fall | input | NCH | Feedback above the lower window limit (about 80 %) |
| fb_ov | input | NCH | Feedback above the overvoltage limit (about 113 %) |
| fault_in | input | 1 | Protection block fault; forces power-good low |
| ss_ref | output | NCH*REF_W | Per-channel soft-start reference codes, channel 0 in the low bits |
| run | output | NCH | Per-channel run flag |
| ldo5_en | output | 1 | Enable for the 5 V regulator |
| ldo3_en | output | 1 | Enable for the 3.3 V regulator |
| pg_drive_n | output | 1 | Power-good pull-down enable: 0 pulls the pin low, 1 releases it |

## Verification
The bench builds the block with two channels, a 4-bit reference code and three clocks per code step, so a full ramp takes 45 clocks instead of the tens of thousands the default parameters give. That short ramp puts the full-scale hold, the single-channel case, the exact release edge after the second ramp ends, and restarts after re-enable all within a few hundred cycles, alongside the hysteresis, overvoltage, fault and power-loss sequences.

// File: rtl/dr_seq_pkg.sv
package dr_seq_pkg;

  typedef enum logic [1:0] {
    WIN_HOLD  = 2'd0,
    WIN_SET   = 2'd1,
    WIN_CLEAR = 2'd2
  } win_act_e;

  function automatic int unsigned div_width(input int unsigned steps);
    return (steps > 1) ? $clog2(steps) : 1;
  endfunction

endpackage

// File: rtl/dr_ss_ramp.sv
module dr_ss_ramp #(
  parameter int unsigned REF_W     = 10,
  parameter int unsigned STEP_CLKS = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  output logic [REF_W-1:0] ref_o,
  output logic             run_o,
  output logic             done_o
);
  import dr_seq_pkg::*;

  localparam int unsigned DIV_W = div_width(STEP_CLKS);
  localparam logic [REF_W-1:0] REF_TOP  = '1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_CLKS - 1);

  logic [DIV_W-1:0] div_q;
  logic [REF_W-1:0] ref_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ref_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= act;
      if (!act) begin
        div_q <= '0;
        ref_q <= '0;
      end else if (ref_q != REF_TOP) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          ref_q <= ref_q + 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign ref_o  = ref_q;
  assign run_o  = run_q;
  assign done_o = (ref_q == REF_TOP);

endmodule

// File: rtl/dr_pg_window.sv
module dr_pg_window (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic above_rise,
  input  logic above_fall,
  input  logic above_ov,
  output logic good_nxt
);
  import dr_seq_pkg::*;

  logic     good_q;
  win_act_e decision;

  always_comb begin
    if (!act || above_ov || !above_fall) decision = WIN_CLEAR;
    else if (above_rise)                 decision = WIN_SET;
    else                                 decision = WIN_HOLD;
  end

  always_comb begin
    unique case (decision)
      WIN_SET:   good_nxt = 1'b1;
      WIN_CLEAR: good_nxt = 1'b0;
      default:   good_nxt = good_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_q <= 1'b0;
    else        good_q <= good_nxt;
  end

endmodule

// File: rtl/dual_rail_seq.sv
module dual_rail_seq #(
  parameter int unsigned NCH       = 2,
  parameter int unsigned REF_W     = 10,
  parameter int unsigned STEP_CLKS = 44
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 por_ok,
  input  logic [NCH-1:0]       en,
  input  logic [NCH-1:0]       fb_rise,
  input  logic [NCH-1:0]       fb_fall,
  input  logic [NCH-1:0]       fb_ov,
  input  logic                 fault_in,
  output logic [NCH*REF_W-1:0] ss_ref,
  output logic [NCH-1:0]       run,
  output logic                 ldo5_en,
  output logic                 ldo3_en,
  output logic                 pg_drive_n
);

  logic [NCH-1:0] act;
  logic [NCH-1:0] done;
  logic [NCH-1:0] good_nxt;
  logic           ldo5_q;
  logic           ldo3_q;
  logic           pg_q;

  assign act = {NCH{por_ok}} & en;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dr_ss_ramp #(
      .REF_W    (REF_W),
      .STEP_CLKS(STEP_CLKS)
    ) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act[g]),
      .ref_o (ss_ref[g*REF_W +: REF_W]),
      .run_o (run[g]),
      .done_o(done[g])
    );

    dr_pg_window u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act[g]),
      .above_rise(fb_rise[g]),
      .above_fall(fb_fall[g]),
      .above_ov  (fb_ov[g]),
      .good_nxt  (good_nxt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldo5_q <= 1'b0;
      ldo3_q <= 1'b0;
      pg_q   <= 1'b0;
    end else begin
      ldo5_q <= por_ok & (|en);
      ldo3_q <= por_ok;
      pg_q   <= por_ok & (&act) & (&done) & (&good_nxt) & ~fault_in;
    end
  end

  assign ldo5_en    = ldo5_q;
  assign ldo3_en    = ldo3_q;
  assign pg_drive_n = pg_q;

endmodule

// File: rtl/dual_rail_seq_chk.sv
module dual_rail_seq_chk #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned REF_W = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 por_ok,
  input logic [NCH-1:0]       en,
  input logic [NCH-1:0]       fb_ov,
  input logic                 fault_in,
  input logic [NCH*REF_W-1:0] ss_ref,
  input logic [NCH-1:0]       run,
  input logic                 ldo5_en,
  input logic                 ldo3_en,
  input logic                 pg_drive_n
);
  localparam logic [REF_W-1:0] REF_TOP = '1;

  for (genvar g = 0; g < NCH; g++) begin : g_ck
    a_r1_ref_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && $past(run[g])) |-> (ss_ref[g*REF_W +: REF_W] >= $past(ss_ref[g*REF_W +: REF_W])));

    a_r2_off_ref_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run[g] |-> (ss_ref[g*REF_W +: REF_W] == '0));

    a_r6_release_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
      pg_drive_n |-> (ss_ref[g*REF_W +: REF_W] == REF_TOP));

    a_r9_ov_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
      fb_ov[g] |=> !pg_drive_n);
  end

  a_r7_release_both_run: assert property (@(posedge clk) disable iff (!rst_n)
    pg_drive_n |-> (&run));

  a_r10_fault_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> !pg_drive_n);

  a_r4_ldo5_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ldo5_en == ($past(por_ok) && (|$past(en)))));

  a_r5_ldo3_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ldo3_en == $past(por_ok)));

endmodule

bind dual_rail_seq dual_rail_seq_chk #(
  .NCH  (NCH),
  .REF_W(REF_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .por_ok    (por_ok),
  .en        (en),
  .fb_ov     (fb_ov),
  .fault_in  (fault_in),
  .ss_ref    (ss_ref),
  .run       (run),
  .ldo5_en   (ldo5_en),
  .ldo3_en   (ldo3_en),
  .pg_drive_n(pg_drive_n)
);

// File: tb/dual_rail_seq_tb.sv
module dual_rail_seq_tb;
  localparam int NCH   = 2;
  localparam int REF_W = 4;
  localparam int STEP  = 3;
  localparam int TOPC  = (1 << REF_W) - 1;
  localparam int CAP   = TOPC * STEP;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 por_ok;
  logic [NCH-1:0]       en, fb_rise, fb_fall, fb_ov;
  logic                 fault_in;
  logic [NCH*REF_W-1:0] ss_ref;
  logic [NCH-1:0]       run;
  logic                 ldo5_en, ldo3_en, pg_drive_n;

  always #10 clk = ~clk;

  dual_rail_seq #(.NCH(NCH), .REF_W(REF_W), .STEP_CLKS(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en(en), .fb_rise(fb_rise),
    .fb_fall(fb_fall), .fb_ov(fb_ov), .fault_in(fault_in), .ss_ref(ss_ref),
    .run(run), .ldo5_en(ldo5_en), .ldo3_en(ldo3_en), .pg_drive_n(pg_drive_n));

  int    n_chk = 0;
  int    n_bad = 0;
  string tag   = "R6";

  // behavioural reference model
  int t_act [NCH];
  bit m_good[NCH];
  bit m_run [NCH];
  bit m_pg, m_l5, m_l3;

  function automatic int ref_of(int t);
    return (t / STEP > TOPC) ? TOPC : t / STEP;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin t_act[i] = 0; m_good[i] = 0; m_run[i] = 0; end
      m_pg = 0; m_l5 = 0; m_l3 = 0;
    end else begin
      bit all_ok;
      bit gn [NCH];
      all_ok = por_ok && !fault_in;
      for (int i = 0; i < NCH; i++) begin
        bit a;
        a = por_ok && en[i];
        if (!a || fb_ov[i] || !fb_fall[i]) gn[i] = 0;
        else if (fb_rise[i])               gn[i] = 1;
        else                               gn[i] = m_good[i];
        if (!a || ref_of(t_act[i]) != TOPC || !gn[i]) all_ok = 0;
      end
      m_pg = all_ok;
      for (int i = 0; i < NCH; i++) begin
        bit a;
        a = por_ok && en[i];
        t_act[i] = a ? ((t_act[i] < CAP) ? t_act[i] + 1 : CAP) : 0;
        m_good[i] = gn[i];
        m_run[i]  = a;
      end
      m_l5 = por_ok && (|en);
      m_l3 = por_ok;
    end
  end

  task automatic chk(bit ok, string req, int act_v, int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic cmp_all();
    for (int i = 0; i < NCH; i++) begin
      int r;
      r = ss_ref[i*REF_W +: REF_W];
      chk(r == ref_of(t_act[i]), "R1 ref", r, ref_of(t_act[i]));
      chk(run[i] == m_run[i], "R3 run", run[i], m_run[i]);
    end
    chk(ldo5_en == m_l5, "R4 ldo5", ldo5_en, m_l5);
    chk(ldo3_en == m_l3, "R5 ldo3", ldo3_en, m_l3);
    chk(pg_drive_n == m_pg, tag, pg_drive_n, m_pg);
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      cmp_all();
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst_n = 0; por_ok = 0; en = '0; fb_rise = '0; fb_fall = '0; fb_ov = '0; fault_in = 0;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(pg_drive_n == 0, "R6 reset pg", pg_drive_n, 0);
    chk(ldo3_en == 0 && ldo5_en == 0, "R5 reset ldo", ldo3_en, 0);
    rst_n = 1;
    // R5: no input power, enables high -> everything off
    en = 2'b11; fb_rise = 2'b11; fb_fall = 2'b11;
    tag = "R5";
    step(4);
    chk(run == 0 && ldo3_en == 0, "R5 no por", run, 0);
    // standby R4
    por_ok = 1; en = 2'b00; tag = "R4";
    step(5);
    chk(ldo3_en == 1 && ldo5_en == 0 && pg_drive_n == 0, "R4 standby", ldo5_en, 0);
    // single channel R7
    en = 2'b01; tag = "R7";
    step(60);
    chk(ss_ref[REF_W-1:0] == TOPC, "R1 full scale", ss_ref[REF_W-1:0], TOPC);
    chk(pg_drive_n == 0, "R7 single channel", pg_drive_n, 0);
    // second channel, release edge R11
    en = 2'b11; tag = "R6";
    step(3);
    chk(ss_ref[REF_W +: REF_W] == 1, "R1 first step", ss_ref[REF_W +: REF_W], 1);
    step(42);
    chk(pg_drive_n == 0, "R6 ramp not done", pg_drive_n, 0);
    tag = "R11";
    step(1);
    chk(pg_drive_n == 1, "R11 release edge", pg_drive_n, 1);
    // hysteresis R8
    tag = "R8"; fb_rise = 2'b00;
    step(3);
    chk(pg_drive_n == 1, "R8 held by lower limit", pg_drive_n, 1);
    tag = "R9"; fb_fall = 2'b10;
    step(1);
    chk(pg_drive_n == 0, "R9 under window", pg_drive_n, 0);
    tag = "R8"; fb_fall = 2'b11;
    step(3);
    chk(pg_drive_n == 0, "R8 needs rising", pg_drive_n, 0);
    fb_rise = 2'b11;
    step(1);
    chk(pg_drive_n == 1, "R8 re-set", pg_drive_n, 1);
    // overvoltage R9
    tag = "R9"; fb_ov = 2'b10;
    step(1);
    chk(pg_drive_n == 0, "R9 overvoltage", pg_drive_n, 0);
    step(2);
    fb_ov = 2'b00;
    step(1);
    chk(pg_drive_n == 1, "R9 ov removed", pg_drive_n, 1);
    // fault R10
    tag = "R10"; fault_in = 1;
    step(1);
    chk(pg_drive_n == 0, "R10 fault", pg_drive_n, 0);
    fault_in = 0;
    step(1);
    chk(pg_drive_n == 1, "R10 fault cleared", pg_drive_n, 1);
    // disable and restart R2
    tag = "R2"; en = 2'b10;
    step(1);
    chk(ss_ref[REF_W-1:0] == 0 && run[0] == 0 && pg_drive_n == 0, "R2 off", ss_ref[REF_W-1:0], 0);
    en = 2'b11;
    step(2);
    chk(ss_ref[REF_W-1:0] == 0, "R2 restart zero", ss_ref[REF_W-1:0], 0);
    step(1);
    chk(ss_ref[REF_W-1:0] == 1, "R2 restart step", ss_ref[REF_W-1:0], 1);
    tag = "R6";
    step(50);
    chk(pg_drive_n == 1, "R11 after restart", pg_drive_n, 1);
    // input power loss R5
    tag = "R5"; por_ok = 0;
    step(2);
    chk(ldo3_en == 0 && ldo5_en == 0 && run == 0 && pg_drive_n == 0, "R5 power loss", ldo3_en, 0);
    por_ok = 1; en = 2'b00; tag = "R4";
    step(3);
    chk(ldo5_en == 0 && ldo3_en == 1, "R4 standby again", ldo5_en, 0);
    finish_run();
  end

endmodule